// File: doc/BRIEF.md
# Guarded Byte-Array Write Controller

This block sits between a register-mapped access port and a small byte-wide storage array that keeps its contents across reset. Software sets a target address and a data byte, then starts a write. A write is launched only when three guards agree: a two-byte key has just been entered, the enable bit is set, and a start-up hold-off period has run out. A start that fails any guard does nothing to the array and leaves a sticky error flag.

While the array is being programmed, the start bit reads back as 1. When the array reports completion, the block reads the cell back and compares it with the intended byte. Any mismatch raises a verify-fail flag. A separate read command copies one array byte into the data register.

Accesses tagged as coming from the external port are dropped completely while protection is on. Internal accesses are never blocked. The array is a behavioural model with a fixed write latency. It also has a weak-cell mask, which forces chosen bits to program as 0, so that verify failures can be produced on demand.

Top module: `nvw_guard_ctrl`

## Requirements
- R1: Reset clears the enable bit, busy, the write-error flag, the verify-fail flag and the read strobe. The control register (select 2) then reads 0x00.
- R2: For the first HOLDOFF_CYCLES cycles after reset, every start request is rejected. Array contents are kept through reset.
- R3: A write is accepted only by a control write that has start (bit 1) and enable (bit 0) both set. The last two accesses before it must be key-register (select 3) writes of 0x55 and then 0xAA. Idle cycles in between are allowed.
- R4: The key sequence returns to idle on three events: a key byte other than the expected next one, any other register access between the key bytes and the start, or a control write. A sequence broken this way cannot launch a write.
- R5: A rejected start leaves the array unchanged and sets the write-error flag (control bit 3). The flag stays set until reset.
- R6: The busy bit (control bit 1) reads 1 from the cycle after acceptance for exactly WR_LAT+3 cycles, then clears by itself. After that the target address holds the written byte.
- R7: A control write with bit 2 set, made while idle, drives rd_strobe high for one cycle, starting the cycle after the request. The cycle after that, the data register (select 1) holds the array byte at the address register (select 0). While busy, such a request is ignored: no strobe and no change to the data register.
- R8: With protect_en high, an access with acc_ext high has no effect on any state and reads 0x00. With protect_en low, the same access works normally.
- R9: After each write, the cell is read back and compared with the intended byte. A mismatch sets verify-fail (control bit 4), for example a 1 that reads back as 0 through the weak-cell mask. The flag is cleared when the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Register write access this cycle |
| acc_rd | input | 1 | Register read access this cycle |
| acc_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| acc_wdata | input | 8 | Write data |
| acc_ext | input | 1 | Access comes from the external port |
| protect_en | input | 1 | Block external-port accesses |
| cell_weak_mask | input | 8 | Array model: bits forced to 0 when programmed |
| acc_rdata | output | 8 | Read data of the selected register |
| rd_strobe | output | 1 | One-cycle pulse for an accepted array read |

## Verification
The assertions check, on every cycle, the invariants that do not depend on stimulus:
- Reset leaves every flag clear.
- Busy never appears before the hold-off has expired, and never lasts longer than WR_LAT+3 cycles.
- An accepted write always has the enable bit set, and verify-fail is clear when it starts.
- The error flag never drops without a reset.
- The read strobe is a single pulse that never overlaps busy.

Only the bench scenarios can show the rest:
- Broken or incomplete key sequences really are refused.
- Blocked external accesses leave the state untouched.
- Array contents survive a reset.
- Read-back values and verify results match the bytes and weak-cell masks applied.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } nvw_sel_e;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_ARMED
    } nvw_ul_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_CHECK
    } nvw_sq_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CB_WEN   = 0;
    localparam int CB_START = 1;
    localparam int CB_RD    = 2;
    localparam int CB_WERR  = 3;
    localparam int CB_VFAIL = 4;

    typedef struct packed {
        logic wen;
        logic start;
        logic rd;
    } nvw_cmd_t;

    typedef struct packed {
        logic wen;
        logic busy;
        logic werr;
        logic vfail;
    } nvw_stat_t;

    function automatic nvw_cmd_t decode_cmd(input logic [7:0] v);
        nvw_cmd_t c;
        c.wen   = v[CB_WEN];
        c.start = v[CB_START];
        c.rd    = v[CB_RD];
        return c;
    endfunction

    function automatic logic [7:0] pack_status(input nvw_stat_t s);
        logic [7:0] r;
        r = 8'h00;
        r[CB_WEN]   = s.wen;
        r[CB_START] = s.busy;
        r[CB_WERR]  = s.werr;
        r[CB_VFAIL] = s.vfail;
        return r;
    endfunction

endpackage

// File: rtl/nvw_holdoff.sv
module nvw_holdoff #(
    parameter int HOLDOFF_CYCLES = 3600000
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    generate
        if (HOLDOFF_CYCLES == 0) begin : g_none
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign done = 1'b1;
        end else begin : g_cnt
            localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
            localparam logic [CW-1:0] LIM = CW'(HOLDOFF_CYCLES);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt != LIM)
                    cnt <= cnt + 1'b1;
            end

            assign done = (cnt == LIM);
        end
    endgenerate
endmodule

// File: rtl/nvw_unlock.sv
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_live,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       armed
);
    nvw_ul_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (acc_live) begin
            if (key_wr) begin
                unique case (st)
                    UL_IDLE: st_nx = (key_byte == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
                    UL_HALF: st_nx = (key_byte == KEY_SECOND) ? UL_ARMED : UL_IDLE;
                    default: st_nx = UL_IDLE;
                endcase
            end else begin
                st_nx = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= UL_IDLE;
        else
            st <= st_nx;
    end

    assign armed = (st == UL_ARMED);
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
    parameter int AW     = 8,
    parameter int WR_LAT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [7:0]    weak_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          done
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WR_LAT + 1);
    localparam logic [CW-1:0] LAT_V = CW'(WR_LAT);

    logic [7:0]    cells [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (wr_go) begin
                cnt <= LAT_V;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !wr_go && cnt == CW'(1))
            cells[wr_addr] <= wr_data & ~weak_mask;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq
    import nvw_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          arr_done,
    input  logic [7:0]    arr_rdata,
    output logic          busy,
    output logic          wr_go,
    output logic [AW-1:0] tgt_addr,
    output logic [7:0]    tgt_data,
    output logic          vfail
);
    nvw_sq_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            vfail    <= 1'b0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        tgt_addr <= req_addr;
                        tgt_data <= req_data;
                        vfail    <= 1'b0;
                        st       <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: st <= SQ_WAIT;
                SQ_WAIT:   if (arr_done) st <= SQ_CHECK;
                default: begin
                    vfail <= (arr_rdata != tgt_data);
                    st    <= SQ_IDLE;
                end
            endcase
        end
    end

    assign busy  = (st != SQ_IDLE);
    assign wr_go = (st == SQ_LAUNCH);
endmodule

// File: rtl/nvw_guard_ctrl.sv
module nvw_guard_ctrl
    import nvw_pkg::*;
#(
    parameter int AW             = 8,
    parameter int WR_LAT         = 16,
    parameter int HOLDOFF_CYCLES = 3600000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_wr,
    input  logic       acc_rd,
    input  logic [1:0] acc_sel,
    input  logic [7:0] acc_wdata,
    input  logic       acc_ext,
    input  logic       protect_en,
    input  logic [7:0] cell_weak_mask,
    output logic [7:0] acc_rdata,
    output logic       rd_strobe
);
    nvw_sel_e      sel;
    nvw_cmd_t      cmd;
    nvw_stat_t     stat;
    logic          blocked, live, live_wr, ctrl_wr, key_wr;
    logic          armed, hold_done, accept, start_rej, rd_req;
    logic          busy, wr_go, arr_done, vfail;
    logic [AW-1:0] addr_q, tgt_addr, arr_raddr;
    logic [7:0]    data_q, tgt_data, arr_rdata;
    logic          wen_q, werr_q, rd_pend;

    assign sel     = nvw_sel_e'(acc_sel);
    assign cmd     = decode_cmd(acc_wdata);
    assign blocked = acc_ext & protect_en;
    assign live    = (acc_wr | acc_rd) & ~blocked;
    assign live_wr = live & acc_wr;
    assign ctrl_wr = live_wr & (sel == SEL_CTRL);
    assign key_wr  = live_wr & (sel == SEL_KEY);

    nvw_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .acc_live (live),
        .key_wr   (key_wr),
        .key_byte (acc_wdata),
        .armed    (armed)
    );

    nvw_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
        .clk  (clk),
        .rst  (rst),
        .done (hold_done)
    );

    assign accept    = ctrl_wr & cmd.start & cmd.wen & armed & hold_done & ~busy;
    assign start_rej = ctrl_wr & cmd.start & ~accept;
    assign rd_req    = ctrl_wr & cmd.rd & ~busy & ~accept;

    nvw_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (addr_q),
        .req_data  (data_q),
        .arr_done  (arr_done),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .wr_go     (wr_go),
        .tgt_addr  (tgt_addr),
        .tgt_data  (tgt_data),
        .vfail     (vfail)
    );

    assign arr_raddr = busy ? tgt_addr : addr_q;

    nvw_array #(.AW(AW), .WR_LAT(WR_LAT)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .wr_addr   (tgt_addr),
        .wr_data   (tgt_data),
        .weak_mask (cell_weak_mask),
        .rd_addr   (arr_raddr),
        .rd_data   (arr_rdata),
        .done      (arr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            wen_q   <= 1'b0;
            werr_q  <= 1'b0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= rd_req;
            if (live_wr && sel == SEL_ADDR)
                addr_q <= acc_wdata[AW-1:0];
            if (rd_pend)
                data_q <= arr_rdata;
            else if (live_wr && sel == SEL_DATA)
                data_q <= acc_wdata;
            if (ctrl_wr)
                wen_q <= cmd.wen;
            if (start_rej)
                werr_q <= 1'b1;
        end
    end

    assign rd_strobe = rd_pend;

    assign stat.wen   = wen_q;
    assign stat.busy  = busy;
    assign stat.werr  = werr_q;
    assign stat.vfail = vfail;

    always_comb begin
        acc_rdata = 8'h00;
        if (!blocked) begin
            unique case (sel)
                SEL_ADDR: acc_rdata = 8'(addr_q);
                SEL_DATA: acc_rdata = data_q;
                SEL_CTRL: acc_rdata = pack_status(stat);
                default:  acc_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nvw_guard_chk.sv
module nvw_guard_chk #(
    parameter int HOLDOFF_CYCLES = 3600000,
    parameter int WR_LAT         = 16
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic wen,
    input logic werr,
    input logic vfail,
    input logic rd_strobe
);
    int since_rst;
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 0;
        else if (since_rst < HOLDOFF_CYCLES)
            since_rst <= since_rst + 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_run <= 0;
        else
            busy_run <= busy_run + 1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !wen && !werr && !vfail && !rd_strobe));

    a_r2_no_write_in_holdoff: assert property (@(posedge clk) disable iff (rst)
        busy |-> (since_rst >= HOLDOFF_CYCLES));

    a_r3_accept_needs_wen: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wen);

    a_r5_werr_sticky: assert property (@(posedge clk) disable iff (rst)
        werr |=> werr);

    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < WR_LAT + 3));

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !rd_strobe);

    a_r7_strobe_not_busy: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !busy);

    a_r9_vfail_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !vfail);
endmodule

bind nvw_guard_ctrl nvw_guard_chk #(
    .HOLDOFF_CYCLES (HOLDOFF_CYCLES),
    .WR_LAT         (WR_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .wen       (wen_q),
    .werr      (werr_q),
    .vfail     (vfail),
    .rd_strobe (rd_strobe)
);

// File: tb/tb_nvw_guard_ctrl.sv
module tb_nvw_guard_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 4;
    localparam int LAT  = 4;
    localparam int HOLD = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_wr = 1'b0, acc_rd = 1'b0, acc_ext = 1'b0, protect_en = 1'b0;
    logic [1:0] acc_sel = 2'd0;
    logic [7:0] acc_wdata = 8'h00, cell_weak_mask = 8'h00;
    logic [7:0] acc_rdata;
    logic       rd_strobe;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvw_guard_ctrl #(.AW(AW), .WR_LAT(LAT), .HOLDOFF_CYCLES(HOLD)) dut (
        .clk            (clk),
        .rst            (rst),
        .acc_wr         (acc_wr),
        .acc_rd         (acc_rd),
        .acc_sel        (acc_sel),
        .acc_wdata      (acc_wdata),
        .acc_ext        (acc_ext),
        .protect_en     (protect_en),
        .cell_weak_mask (cell_weak_mask),
        .acc_rdata      (acc_rdata),
        .rd_strobe      (rd_strobe)
    );

    function automatic logic [7:0] exp_cell(input logic [7:0] d, input logic [7:0] m);
        return d & ~m;
    endfunction

    function automatic logic exp_vfail(input logic [7:0] d, input logic [7:0] m);
        return |(d & m);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] sel, input logic [7:0] d,
                       input logic ext, output logic [7:0] q);
        acc_wr = wr; acc_rd = ~wr; acc_sel = sel; acc_wdata = d; acc_ext = ext;
        #1 q = acc_rdata;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; acc_ext = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        logic [7:0] q;
        acc(1'b1, sel, d, 1'b0, q);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] q);
        acc(1'b0, sel, 8'h00, 1'b0, q);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic unlock_start(input logic [7:0] ctrl);
        wr(2'd3, 8'h55);
        wr(2'd3, 8'hAA);
        wr(2'd2, ctrl);
    endtask

    task automatic full_write(input logic [7:0] a, input logic [7:0] d,
                              output int busy_n, output logic [7:0] ctrl_after);
        logic [7:0] q;
        wr(2'd0, a);
        wr(2'd1, d);
        unlock_start(8'h03);
        busy_n = 0;
        rd(2'd2, q);
        while (q[1] && busy_n < 100) begin
            busy_n++;
            rd(2'd2, q);
        end
        ctrl_after = q;
    endtask

    task automatic read_cell(input logic [7:0] a, output logic [7:0] q);
        wr(2'd0, a);
        wr(2'd2, 8'h04);
        idle(1);
        rd(2'd1, q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] q, c;
        int n, seed;
        seed = $urandom(32'd2024);

        idle(2);
        // R1: reset state
        rd(2'd2, q);
        check("R1 ctrl during reset", q, 8'h00);
        rst = 1'b0;
        rd(2'd2, q);
        check("R1 ctrl after reset", q, 8'h00);
        check("R1 strobe low", {7'b0, rd_strobe}, 8'h00);

        // R2: start inside hold-off rejected
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h3C);
        unlock_start(8'h03);
        rd(2'd2, q);
        check("R2 busy in holdoff", {7'b0, q[1]}, 8'h00);
        check("R2 werr in holdoff", {7'b0, q[3]}, 8'h01);
        idle(HOLD);

        // R3, R6: valid write, busy duration and content
        full_write(8'h03, 8'h3C, n, c);
        check("R6 busy cycles", 8'(n), 8'(LAT + 3));
        read_cell(8'h03, q);
        check("R3 write landed", q, 8'h3C);

        // R2: contents kept through reset, rejected in hold-off
        do_reset();
        rd(2'd2, q);
        check("R1 ctrl after second reset", q, 8'h00);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'hC3);
        unlock_start(8'h03);
        rd(2'd2, q);
        check("R2 werr second holdoff", {7'b0, q[3]}, 8'h01);
        idle(HOLD);
        read_cell(8'h03, q);
        check("R2 cell kept", q, 8'h3C);

        // R3: enable low in start write
        do_reset(); idle(HOLD);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h99);
        unlock_start(8'h02);
        rd(2'd2, q);
        check("R3 wen low rejected", q, 8'h08);
        read_cell(8'h03, q);
        check("R5 array unchanged wen low", q, 8'h3C);

        // R4: wrong second key byte
        do_reset(); idle(HOLD);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h11);
        wr(2'd3, 8'h55);
        wr(2'd3, 8'h12);
        wr(2'd3, 8'hAA);
        wr(2'd2, 8'h03);
        rd(2'd2, q);
        check("R4 wrong key rejected", q, 8'h09);

        // R4: intervening access
        do_reset(); idle(HOLD);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h11);
        wr(2'd3, 8'h55);
        wr(2'd3, 8'hAA);
        rd(2'd0, q);
        wr(2'd2, 8'h03);
        rd(2'd2, q);
        check("R4 intervening access rejected", q, 8'h09);
        read_cell(8'h03, q);
        check("R5 array unchanged after R4", q, 8'h3C);

        // R5: sticky across a later good write
        full_write(8'h03, 8'h11, n, c);
        check("R5 werr stays set", {7'b0, c[3]}, 8'h01);
        read_cell(8'h03, q);
        check("R3 write after recovery", q, 8'h11);

        // R7: read strobe timing
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h04);
        check("R7 strobe high", {7'b0, rd_strobe}, 8'h01);
        idle(1);
        check("R7 strobe one cycle", {7'b0, rd_strobe}, 8'h00);
        rd(2'd1, q);
        check("R7 data loaded", q, 8'h11);

        // R7: read ignored while busy
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h77);
        unlock_start(8'h03);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h05);
        check("R7 no strobe while busy", {7'b0, rd_strobe}, 8'h00);
        idle(LAT + 4);
        rd(2'd1, q);
        check("R7 data untouched while busy", q, 8'h00);

        // R8: protection
        protect_en = 1'b1;
        acc(1'b1, 2'd1, 8'hA5, 1'b1, q);
        rd(2'd1, q);
        check("R8 blocked write no effect", q, 8'h00);
        wr(2'd1, 8'h42);
        acc(1'b0, 2'd1, 8'h00, 1'b1, q);
        check("R8 blocked read zero", q, 8'h00);
        rd(2'd1, q);
        check("R8 internal read allowed", q, 8'h42);
        protect_en = 1'b0;
        acc(1'b1, 2'd1, 8'hA5, 1'b1, q);
        acc(1'b0, 2'd1, 8'h00, 1'b1, q);
        check("R8 external allowed unprotected", q, 8'hA5);

        // R9: verify failure and clear
        cell_weak_mask = 8'h01;
        full_write(8'h06, 8'hFF, n, c);
        check("R9 vfail set", {7'b0, c[4]}, 8'h01);
        cell_weak_mask = 8'h00;
        read_cell(8'h06, q);
        check("R9 weak cell content", q, 8'hFE);
        wr(2'd1, 8'h81);
        unlock_start(8'h03);
        rd(2'd2, q);
        check("R9 vfail cleared at start", {6'b0, q[4], q[1]}, 8'h01);
        idle(LAT + 4);
        rd(2'd2, q);
        check("R9 vfail clear after good write", {7'b0, q[4]}, 8'h00);
        cell_weak_mask = 8'h80;
        full_write(8'h07, 8'h0F, n, c);
        check("R9 masked zero bit passes", {7'b0, c[4]}, 8'h00);
        cell_weak_mask = 8'h00;

        // Random writes (R3, R6, R9)
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, d, m;
            a = 8'($urandom_range(0, (1 << AW) - 1));
            d = 8'($urandom);
            m = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            cell_weak_mask = m;
            full_write(a, d, n, c);
            cell_weak_mask = 8'h00;
            check("R6 random busy cycles", 8'(n), 8'(LAT + 3));
            check("R9 random vfail", {7'b0, c[4]}, {7'b0, exp_vfail(d, m)});
            read_cell(a, q);
            check("R3 random readback", q, exp_cell(d, m));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule